// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Periodic Timers

This block gathers five interrupt sources and offers the most urgent one to a small CPU core as a vector index. The core takes the offer with an acknowledge handshake. The sources are:

- two external pins, each with its own edge polarity;
- a one-cycle completion pulse from a serial port;
- two internal periodic timers.

Each source has an enable flag, and a global enable sits above all of them. A pending flag per source stores a request until the core takes it. A shared prescaler divides the system clock down to a 100 µs tick. Each timer counts those ticks to one of eight fixed periods.

The block tracks nesting with an in-service mask. A vector is offered only when its priority is above every level now in service. At most four levels may be active at once. A return-from-interrupt strobe releases the most recent level.

The offer is made by a three-state arbiter:

- `ARB_IDLE` moves to `ARB_OFFER` when a permitted candidate exists. It moves to `ARB_FULL` when four levels are active.
- `ARB_OFFER` holds the request and a latched vector. It returns to `ARB_IDLE` on acknowledge.
- `ARB_FULL` returns to `ARB_IDLE` on a return strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `irq_pending` is all zero and `nest_depth` is 0.
- R2: Each external pin passes through a two-flop synchronizer and is compared with its previous sampled value. `ext_rise[i]`=1 selects rising-edge detection and 0 selects falling-edge detection; an edge of the other direction sets nothing.
- R3: An event from a source whose enable bit is 0 does not set that source's pending flag.
- R4: While `glob_en` is 0, pending flags still collect events but `irq_req` is never newly raised.
- R5: Vector codes are ext0=0, ext1=1, serial=2, timer0=3, timer1=4. Among eligible pending sources the lowest code is offered first.
- R6: Acknowledge while `irq_req` is high clears only that source's pending flag, marks that level in service and drops `irq_req` in the next cycle.
- R7: A pending source is offered only if its code is strictly lower than every code in service. Equal or lower priority waits.
- R8: With four levels in service no request is offered. A return strobe releases a level and lets the waiting request through.
- R9: Events that arrive while a source's flag is already pending merge into one request.
- R10: The timer period codes 0..7 select 1, 10, 20, 50, 100, 500, 1250 and 2500 ticks (100 µs to 250 ms). A tick is CLK_PER_TICK clocks. Timer 0 maps to pending bit 3 and timer 1 to pending bit 4.
- R11: Writing a code to a timer (`tmr_wr[i]` with `tmr_code`) restarts its count. Its first expiry comes one full period later, within one tick.
- R12: While `irq_req` is high and not acknowledged, `irq_vec` does not change, even if a higher source becomes pending.
- R13: A return strobe releases the highest-priority level in service. With nothing in service it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 2 | External interrupt pins (asynchronous) |
| ext_rise | input | 2 | Per-pin polarity: 1 rising, 0 falling |
| ext_en | input | 2 | Per-pin interrupt enable |
| sio_done | input | 1 | Serial-port completion pulse |
| sio_en | input | 1 | Serial source enable |
| tmr_wr | input | 2 | Per-timer period-code write strobe |
| tmr_code | input | 3 | Period code written by `tmr_wr` |
| tmr_en | input | 2 | Per-timer interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU accepts the offered vector |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | A vector is offered |
| irq_vec | output | 3 | Offered vector code |
| irq_pending | output | 5 | Pending flags, indexed by vector code |
| nest_depth | output | 3 | Number of levels in service |

## Verification
The bench builds the block with CLK_PER_TICK=4 and the default nesting limit of four. At four clocks per tick, even the 2500-tick period takes only 10,000 cycles. This lets the bench measure every timer menu entry it selects as an exact cycle interval, including the longest. The four-level limit is reached by stacking timer 1, timer 0, serial and ext1 in rising priority order. A final ext0 request then waits blocked until a return strobe frees a level.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int SRC_COUNT = 5;
    localparam int EXT_COUNT = 2;
    localparam int TMR_COUNT = 2;
    localparam int PERIOD_W  = 12;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_FULL  = 2'd2
    } arb_state_t;

    // Period menu in 100 us ticks.
    function automatic logic [PERIOD_W-1:0] period_ticks(input logic [2:0] code);
        logic [PERIOD_W-1:0] p;
        case (code)
            3'd0:    p = 12'd1;
            3'd1:    p = 12'd10;
            3'd2:    p = 12'd20;
            3'd3:    p = 12'd50;
            3'd4:    p = 12'd100;
            3'd5:    p = 12'd500;
            3'd6:    p = 12'd1250;
            default: p = 12'd2500;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pirq_edge_det.sv
module pirq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic evt
);
    logic sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign evt = rise_sel ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && $stable(rise_sel)) |=> !(evt && rise_sel == $past(rise_sel))); // R2

endmodule

// File: rtl/pirq_tick_gen.sv
module pirq_tick_gen #(
    parameter int CLK_PER_TICK = 1000,
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= CW'(CLK_PER_TICK - 1);
        else if (div_q == '0)   div_q <= CW'(CLK_PER_TICK - 1);
        else                    div_q <= div_q - 1'b1;
    end

    assign tick = (div_q == '0);

    generate
        if (CLK_PER_TICK > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R10
        end
    endgenerate

endmodule

// File: rtl/pirq_period_timer.sv
module pirq_period_timer
    import prio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr,
    input  logic [2:0] code_in,
    output logic       fire
);
    logic [2:0]          code_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] per_new, per_cur;

    assign per_new = period_ticks(code_in);
    assign per_cur = period_ticks(code_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= 3'd0;
            cnt_q  <= '0;
        end else if (wr) begin
            code_q <= code_in;
            cnt_q  <= per_new - 1'b1;
        end else if (tick) begin
            cnt_q  <= (cnt_q == '0) ? per_cur - 1'b1 : cnt_q - 1'b1;
        end
    end

    assign fire = tick && !wr && (cnt_q == '0);

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && code_in != 3'd0) |=> !fire); // R11
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_cur); // R10

endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NSRC     = SRC_COUNT,
    parameter int MAX_NEST = 4,
    localparam int VEC_W   = $clog2(NSRC),
    localparam int DEPTH_W = $clog2(MAX_NEST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_evt,
    input  logic [NSRC-1:0]    src_en,
    input  logic               glob_en,
    input  logic               irq_ack,
    input  logic               irq_reti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NSRC-1:0]    pending,
    output logic [DEPTH_W-1:0] nest_depth
);
    arb_state_t          state_q, state_d;
    logic [NSRC-1:0]     pend_q, pend_d, isr_q, isr_d, elig;
    logic [VEC_W-1:0]    vec_q;
    logic [VEC_W:0]      best_idx, top_idx;
    logic                best_any, cand_ok, nest_full, take, pop;
    logic [DEPTH_W-1:0]  depth;

    assign elig = pend_q & src_en & {NSRC{glob_en}};

    // Lowest eligible code and lowest in-service code (NSRC when none).
    always_comb begin
        best_any = 1'b0;
        best_idx = (VEC_W+1)'(NSRC);
        top_idx  = (VEC_W+1)'(NSRC);
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                best_any = 1'b1;
                best_idx = (VEC_W+1)'(i);
            end
            if (isr_q[i]) top_idx = (VEC_W+1)'(i);
        end
    end

    always_comb begin
        depth = '0;
        for (int i = 0; i < NSRC; i++) depth = depth + DEPTH_W'(isr_q[i]);
    end

    assign nest_full = (depth >= DEPTH_W'(MAX_NEST));
    assign cand_ok   = best_any && (best_idx < top_idx) && !nest_full;
    assign take      = (state_q == ARB_OFFER) && irq_ack;
    assign pop       = irq_reti && (isr_q != '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (nest_full)    state_d = ARB_FULL;
                else if (cand_ok) state_d = ARB_OFFER;
            end
            ARB_OFFER: begin
                if (irq_ack)      state_d = ARB_IDLE;
            end
            ARB_FULL: begin
                if (irq_reti)     state_d = ARB_IDLE;
            end
            default:              state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Vector latch, taken on the move into ARB_OFFER
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (state_q == ARB_IDLE && state_d == ARB_OFFER)
            vec_q <= best_idx[VEC_W-1:0];
    end

    // Pending and in-service masks
    always_comb begin
        pend_d = pend_q;
        isr_d  = isr_q;
        if (take) pend_d[vec_q] = 1'b0;
        pend_d = pend_d | (src_evt & src_en);
        if (pop)  isr_d = isr_q & (isr_q - 1'b1);
        if (take) isr_d[vec_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            isr_q  <= '0;
        end else begin
            pend_q <= pend_d;
            isr_q  <= isr_d;
        end
    end

    // Outputs
    always_comb begin
        irq_req    = (state_q == ARB_OFFER);
        irq_vec    = vec_q;
        pending    = pend_q;
        nest_depth = depth;
    end

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec))); // R12
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(src_evt[vec_q] && src_en[vec_q])) |=> !pending[$past(vec_q)]); // R6
    AST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ({1'b0, irq_vec} < top_idx)); // R7
    AST_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_W'(MAX_NEST)); // R8
    AST_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nest_full |-> !irq_req); // R8

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int CLK_PER_TICK = 1000,
    parameter int MAX_NEST     = 4,
    localparam int VEC_W       = $clog2(SRC_COUNT),
    localparam int DEPTH_W     = $clog2(MAX_NEST + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EXT_COUNT-1:0] ext_pin,
    input  logic [EXT_COUNT-1:0] ext_rise,
    input  logic [EXT_COUNT-1:0] ext_en,
    input  logic                 sio_done,
    input  logic                 sio_en,
    input  logic [TMR_COUNT-1:0] tmr_wr,
    input  logic [2:0]           tmr_code,
    input  logic [TMR_COUNT-1:0] tmr_en,
    input  logic                 glob_en,
    input  logic                 irq_ack,
    input  logic                 irq_reti,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [SRC_COUNT-1:0] irq_pending,
    output logic [DEPTH_W-1:0]   nest_depth
);
    logic [EXT_COUNT-1:0] ext_evt;
    logic [TMR_COUNT-1:0] tmr_fire;
    logic                 tick;
    logic [SRC_COUNT-1:0] src_evt, src_en;

    genvar gi;
    generate
        for (gi = 0; gi < EXT_COUNT; gi++) begin : g_ext
            pirq_edge_det u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (ext_pin[gi]),
                .rise_sel (ext_rise[gi]),
                .evt      (ext_evt[gi])
            );
        end
    endgenerate

    pirq_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (gi = 0; gi < TMR_COUNT; gi++) begin : g_tmr
            pirq_period_timer u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .wr      (tmr_wr[gi]),
                .code_in (tmr_code),
                .fire    (tmr_fire[gi])
            );
        end
    endgenerate

    // Vector order: ext pins, serial, timers.
    assign src_evt = {tmr_fire, sio_done, ext_evt};
    assign src_en  = {tmr_en,   sio_en,   ext_en};

    pirq_arbiter #(.NSRC(SRC_COUNT), .MAX_NEST(MAX_NEST)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (src_evt),
        .src_en     (src_en),
        .glob_en    (glob_en),
        .irq_ack    (irq_ack),
        .irq_reti   (irq_reti),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .pending    (irq_pending),
        .nest_depth (nest_depth)
    );

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    localparam int TB_TICK = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ext_pin, ext_rise, ext_en, tmr_wr, tmr_en;
    logic       sio_done, sio_en, glob_en, irq_ack, irq_reti;
    logic [2:0] tmr_code;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic [4:0] irq_pending;
    logic [2:0] nest_depth;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0, sb_on = 0, sb_busy = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prio_irq_ctrl #(.CLK_PER_TICK(TB_TICK)) dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise(ext_rise),
        .ext_en(ext_en), .sio_done(sio_done), .sio_en(sio_en), .tmr_wr(tmr_wr),
        .tmr_code(tmr_code), .tmr_en(tmr_en), .glob_en(glob_en),
        .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_pending(irq_pending), .nest_depth(nest_depth)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ticks(input int code);
        case (code)
            0: return 1;    1: return 10;   2: return 20;   3: return 50;
            4: return 100;  5: return 500;  6: return 1250; default: return 2500;
        endcase
    endfunction

    // Scoreboard monitor: pops the expected vector for each offer, then acks and returns.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_on && irq_req) begin
                sb_busy = 1;
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected offer", irq_vec, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(irq_vec == 3'(e), "R5 vector order", irq_vec, e);
                end
                irq_ack = 1;
                @(negedge clk); irq_ack = 0; irq_reti = 1;
                @(negedge clk); irq_reti = 0;
                sb_busy = 0;
            end
        end
    end

    task automatic wait_sb(input int lim);
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !sb_busy) break;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected offers seen", exp_q.size(), 0);
    endtask

    task automatic wait_req(input int lim, output bit found);
        found = 0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (irq_req) begin found = 1; break; end
        end
    endtask

    task automatic set_pin(input int i, input logic v);
        ext_pin[i] = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_sio();
        sio_done = 1; @(negedge clk); sio_done = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_ack();
        irq_ack = 1; @(negedge clk); irq_ack = 0;
    endtask

    task automatic do_reti();
        irq_reti = 1; @(negedge clk); irq_reti = 0;
    endtask

    // Period measurement on timer 1 (vector 4): first expiry after the write, then two intervals.
    task automatic measure(input int code);
        int t0, p;
        int t[3];
        bit f;
        p = exp_ticks(code) * TB_TICK;
        tmr_code = 3'(code); tmr_wr = 2'b10; tmr_en = 2'b10;
        t0 = cyc;
        @(negedge clk); tmr_wr = 2'b00;
        for (int k = 0; k < 3; k++) begin
            wait_req(2 * p + 50, f);
            t[k] = cyc;
            chk(f && irq_vec == 3'd4, "R10 timer1 offer", irq_vec, 4);
            do_ack(); do_reti();
        end
        tmr_en = 2'b00;
        chk((t[0] - t0) >= p - 2 && (t[0] - t0) <= p + 3, "R11 first expiry after write", t[0] - t0, p);
        chk(t[1] - t[0] == p, "R10 period interval a", t[1] - t[0], p);
        chk(t[2] - t[1] == p, "R10 period interval b", t[2] - t[1], p);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit f;
        rst_n = 0; ext_pin = 0; ext_rise = 0; ext_en = 0; tmr_wr = 0; tmr_en = 0;
        sio_done = 0; sio_en = 0; glob_en = 0; irq_ack = 0; irq_reti = 0; tmr_code = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(irq_req == 0, "R1 reset request", irq_req, 0);
        chk(irq_pending == 0, "R1 reset pending", irq_pending, 0);
        chk(nest_depth == 0, "R1 reset depth", nest_depth, 0);

        // R13: return strobe with nothing in service
        do_reti(); @(negedge clk);
        chk(nest_depth == 0 && !irq_req, "R13 empty return ignored", nest_depth, 0);

        // R2: rising edge on ext0
        ext_en = 2'b11; ext_rise = 2'b11;
        set_pin(0, 1);
        chk(irq_pending[0] == 1, "R2 rising edge sets ext0", irq_pending, 1);
        set_pin(0, 0);
        sb_on = 1; exp_q.push_back(0); glob_en = 1;
        wait_sb(50);
        chk(irq_pending == 0, "R6 pending cleared after service", irq_pending, 0);

        // R2: falling polarity on ext1
        ext_rise[1] = 0;
        set_pin(1, 1);
        chk(irq_pending[1] == 0 && !irq_req, "R2 rising ignored under falling select", irq_pending, 0);
        exp_q.push_back(1);
        set_pin(1, 0);
        wait_sb(50);

        // R3: disabled source
        ext_en[0] = 0;
        set_pin(0, 1);
        chk(irq_pending[0] == 0 && !irq_req, "R3 disabled source ignored", irq_pending, 0);
        set_pin(0, 0);
        ext_en[0] = 1;

        // R4 and R5: collect with global enable low, then release in priority order
        glob_en = 0; sio_en = 1;
        pulse_sio();
        set_pin(1, 1);
        set_pin(1, 0);
        chk(irq_pending == 5'b00110 && !irq_req, "R4 held while global off", irq_pending, 6);
        exp_q.push_back(1); exp_q.push_back(2);
        glob_en = 1;
        wait_sb(80);

        // R9: merged events
        glob_en = 0;
        pulse_sio();
        pulse_sio();
        exp_q.push_back(2);
        glob_en = 1;
        wait_sb(50);
        repeat (10) @(negedge clk);
        chk(irq_pending == 0 && !irq_req, "R9 two events one request", irq_pending, 0);
        sb_on = 0;

        // R12, R6, R7
        pulse_sio();
        wait_req(20, f);
        chk(f && irq_vec == 3'd2, "R7 serial offered", irq_vec, 2);
        set_pin(0, 1);
        repeat (2) @(negedge clk);
        chk(irq_req && irq_vec == 3'd2, "R12 vector held without ack", irq_vec, 2);
        do_ack();
        chk(!irq_req && irq_pending == 5'b00001 && nest_depth == 1, "R6 ack clears only its flag", irq_pending, 1);
        wait_req(10, f);
        chk(f && irq_vec == 3'd0, "R7 higher source preempts", irq_vec, 0);
        do_ack();
        chk(nest_depth == 2, "R7 two levels", nest_depth, 2);
        pulse_sio();
        repeat (3) @(negedge clk);
        chk(!irq_req && irq_pending[2], "R7 lower priority waits", irq_req, 0);
        do_reti();
        repeat (4) @(negedge clk);
        chk(!irq_req && nest_depth == 1, "R7 equal priority waits", irq_req, 0);
        do_reti();
        wait_req(10, f);
        chk(f && irq_vec == 3'd2 && nest_depth == 0, "R13 return releases top level", irq_vec, 2);
        do_ack(); do_reti(); @(negedge clk);
        chk(nest_depth == 0, "R13 depth back to zero", nest_depth, 0);
        set_pin(0, 0);

        // R8: four-deep nesting
        tmr_code = 3'd0; tmr_wr = 2'b10; tmr_en = 2'b10;
        @(negedge clk); tmr_wr = 2'b00;
        wait_req(20, f);
        chk(f && irq_vec == 3'd4, "R8 level timer1", irq_vec, 4);
        irq_ack = 1; tmr_en = 2'b00; @(negedge clk); irq_ack = 0;
        tmr_wr = 2'b01; tmr_en = 2'b01;
        @(negedge clk); tmr_wr = 2'b00;
        wait_req(20, f);
        chk(f && irq_vec == 3'd3, "R8 level timer0", irq_vec, 3);
        irq_ack = 1; tmr_en = 2'b00; @(negedge clk); irq_ack = 0;
        pulse_sio();
        wait_req(20, f);
        chk(f && irq_vec == 3'd2, "R8 level serial", irq_vec, 2);
        do_ack();
        set_pin(1, 1);
        set_pin(1, 0);
        wait_req(20, f);
        chk(f && irq_vec == 3'd1, "R8 level ext1", irq_vec, 1);
        do_ack();
        chk(nest_depth == 4, "R8 four levels", nest_depth, 4);
        set_pin(0, 1);
        repeat (3) @(negedge clk);
        chk(irq_pending[0] && !irq_req, "R8 blocked at limit", irq_req, 0);
        do_reti();
        wait_req(10, f);
        chk(f && irq_vec == 3'd0 && nest_depth == 3, "R8 release lets request through", irq_vec, 0);
        do_ack();
        for (int k = 0; k < 4; k++) do_reti();
        @(negedge clk);
        chk(nest_depth == 0, "R8 all levels released", nest_depth, 0);
        set_pin(0, 0);

        // R10 and R11: timer periods
        measure(1);
        measure(2);
        measure(4);
        measure(7);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule